// File: doc/BRIEF.md
# Fractional-Step Pixel Subsampling Gate

This block decides which pixels of a raster video stream a statistics unit should count. It watches the pixel-valid strobe, a start-of-line strobe and a start-of-frame strobe. It emits one qualifier per pixel, registered so that it lines up with a one-cycle delayed copy of pixel-valid. The block does not touch pixel data.

Horizontal thinning uses a 16-bit phase accumulator. On every valid pixel the accumulator adds a 17-bit increment, and the pixel is taken when that addition carries past bit 15. This gives fractional sampling rates rather than only integer ones. Vertical thinning takes one line out of every N, counting from the first line of each frame.

Both settings come from shadow registers. These load at start-of-frame or on an explicit update strobe, so a new setting never takes effect partway through a line.

Top module: `pix_subsample_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sample_en_o` and `pix_valid_q_o` are 0.
- R2: `pix_valid_q_o` equals `pix_valid_i` of the previous cycle. `sample_en_o` refers to the pixel presented in the previous cycle and is never 1 unless `pix_valid_q_o` is 1.
- R3: With an increment of 65536, every valid pixel of a selected line is sampled. With 32768, the second, fourth and later even-numbered pixels of the line are sampled, and the first pixel is not.
- R4: For any increment h, the pixel with zero-based index j within its line is sampled exactly when floor((j+1)·h/65536) > floor(j·h/65536). Cycles with `pix_valid_i` low do not advance the accumulator.
- R5: An increment of 0 never samples. Any increment above 65536 samples every valid pixel of a selected line.
- R6: The phase accumulator restarts from zero at every start-of-line, so each line follows the R4 pattern on its own whatever the previous line left behind.
- R7: A pulse on `line_start_i` marks the first pixel of a new line and may coincide with that pixel. A line counter advances on each line start and wraps to 0 when it reaches step−1. A line is selected when the counter is 0.
- R8: A programmed vertical step of 0, 1 or 2 behaves exactly like a step of 3.
- R9: A pulse on `frame_start_i`, given together with the first line start, forces the line counter to 0, so the first line of every frame is selected.
- R10: `cfg_hinc_i` and `cfg_vstep_i` are captured only in a cycle where `frame_start_i` or `cfg_update_i` is 1. They apply from that cycle on. At all other times, changes on these inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid_i | input | 1 | A pixel is present this cycle |
| line_start_i | input | 1 | Start of a new line |
| frame_start_i | input | 1 | Start of a new frame, given with the first line start |
| cfg_update_i | input | 1 | Capture the configuration inputs now |
| cfg_hinc_i | input | 17 | Horizontal phase increment (65536 = every pixel) |
| cfg_vstep_i | input | 7 | Vertical step N (one line in N, values below 3 act as 3) |
| pix_valid_q_o | output | 1 | Pixel-valid delayed by one cycle |
| sample_en_o | output | 1 | Sample qualifier for the delayed pixel |

## Verification
The hardest case to reach is a configuration change in the middle of a frame. The new values must stay invisible until a strobe arrives, and the line counter must then continue under the new step from wherever it stood. The bench gets there by running one frame under one setting and changing the configuration inputs between lines with no strobe. It checks that a line already due under the old step is still sampled at the old rate. It then pulses the update strobe alone on an idle cycle and follows the counter through several lines under the new step. Fractional increments are driven with idle gaps between pixels, which shows that only valid pixels advance the phase.

// File: rtl/pix_subsample_gate_pkg.sv
package pix_subsample_gate_pkg;
  localparam int unsigned HINC_W    = 17;
  localparam int unsigned PHASE_W   = 16;
  localparam int unsigned VSTEP_W   = 7;
  localparam int unsigned VSTEP_MIN = 3;
endpackage

// File: rtl/sub_gate_cfg.sv
module sub_gate_cfg #(
  parameter int unsigned HINC_W    = 17,
  parameter int unsigned VSTEP_W   = 7,
  parameter int unsigned VSTEP_MIN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [HINC_W-1:0]  hinc_i,
  input  logic [VSTEP_W-1:0] vstep_i,
  output logic [HINC_W-1:0]  hinc_eff_o,
  output logic [VSTEP_W-1:0] vstep_eff_o,
  output logic [HINC_W-1:0]  hinc_shadow_o
);
  localparam logic [VSTEP_W-1:0] STEP_FLOOR = VSTEP_W'(VSTEP_MIN);

  logic [HINC_W-1:0]  hinc_q, hinc_d;
  logic [VSTEP_W-1:0] vstep_q, vstep_d;
  logic [VSTEP_W-1:0] vstep_clamped;

  // clamp programmed step so the counter always has a defined wrap point
  always_comb begin
    vstep_clamped = (vstep_i < STEP_FLOOR) ? STEP_FLOOR : vstep_i;
    hinc_d        = load_i ? hinc_i : hinc_q;
    vstep_d       = load_i ? vstep_clamped : vstep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hinc_q  <= '0;
      vstep_q <= STEP_FLOOR;
    end else if (load_i) begin
      hinc_q  <= hinc_d;
      vstep_q <= vstep_d;
    end
  end

  // values captured in a strobe cycle apply to that cycle already
  assign hinc_eff_o    = hinc_d;
  assign vstep_eff_o   = vstep_d;
  assign hinc_shadow_o = hinc_q;
endmodule

// File: rtl/sub_gate_hphase.sv
module sub_gate_hphase #(
  parameter int unsigned HINC_W  = 17,
  parameter int unsigned PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid_i,
  input  logic               line_start_i,
  input  logic [HINC_W-1:0]  hinc_i,
  output logic               hit_o,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int unsigned SUM_W = ((HINC_W > PHASE_W) ? HINC_W : PHASE_W) + 1;

  logic [PHASE_W-1:0] acc_q, acc_d, acc_base;
  logic [SUM_W-1:0]   sum;
  logic               acc_en;

  always_comb begin
    acc_base = line_start_i ? '0 : acc_q;
    sum      = SUM_W'(acc_base) + SUM_W'(hinc_i);
    // carry out of the top phase bit selects the pixel
    hit_o    = pix_valid_i && (sum[SUM_W-1:PHASE_W] != '0);
    acc_en   = pix_valid_i || line_start_i;
    acc_d    = pix_valid_i ? sum[PHASE_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign phase_o = acc_q;
endmodule

// File: rtl/sub_gate_vline.sv
module sub_gate_vline #(
  parameter int unsigned VSTEP_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start_i,
  input  logic               frame_start_i,
  input  logic [VSTEP_W-1:0] vstep_i,
  output logic               line_sel_o,
  output logic [VSTEP_W-1:0] count_o
);
  logic [VSTEP_W-1:0] cnt_q, cnt_cur, wrap_at;
  logic               cnt_en;

  always_comb begin
    wrap_at = vstep_i - VSTEP_W'(1);
    if (frame_start_i) begin
      cnt_cur = '0;
    end else if (line_start_i) begin
      cnt_cur = (cnt_q >= wrap_at) ? '0 : cnt_q + VSTEP_W'(1);
    end else begin
      cnt_cur = cnt_q;
    end
    line_sel_o = (cnt_cur == '0);
    cnt_en     = frame_start_i || line_start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_cur;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pix_subsample_gate.sv
module pix_subsample_gate
  import pix_subsample_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid_i,
  input  logic               line_start_i,
  input  logic               frame_start_i,
  input  logic               cfg_update_i,
  input  logic [HINC_W-1:0]  cfg_hinc_i,
  input  logic [VSTEP_W-1:0] cfg_vstep_i,
  output logic               pix_valid_q_o,
  output logic               sample_en_o
);
  logic [HINC_W-1:0]  hinc_eff, hinc_shadow;
  logic [VSTEP_W-1:0] vstep_eff, v_cnt;
  logic [PHASE_W-1:0] h_acc;
  logic               cfg_load, h_hit, v_sel;
  logic               en_d, en_q, vld_q;

  assign cfg_load = frame_start_i || cfg_update_i;

  sub_gate_cfg #(
    .HINC_W(HINC_W), .VSTEP_W(VSTEP_W), .VSTEP_MIN(VSTEP_MIN)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load),
    .hinc_i(cfg_hinc_i), .vstep_i(cfg_vstep_i),
    .hinc_eff_o(hinc_eff), .vstep_eff_o(vstep_eff), .hinc_shadow_o(hinc_shadow)
  );

  sub_gate_hphase #(
    .HINC_W(HINC_W), .PHASE_W(PHASE_W)
  ) u_hphase (
    .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i),
    .line_start_i(line_start_i), .hinc_i(hinc_eff),
    .hit_o(h_hit), .phase_o(h_acc)
  );

  sub_gate_vline #(
    .VSTEP_W(VSTEP_W)
  ) u_vline (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
    .frame_start_i(frame_start_i), .vstep_i(vstep_eff),
    .line_sel_o(v_sel), .count_o(v_cnt)
  );

  always_comb begin
    en_d = h_hit && v_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      vld_q <= pix_valid_i;
    end
  end

  assign sample_en_o   = en_q;
  assign pix_valid_q_o = vld_q;
endmodule

// File: rtl/pix_subsample_gate_chk.sv
module pix_subsample_gate_chk
  import pix_subsample_gate_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               pix_valid_i,
  input logic               line_start_i,
  input logic               frame_start_i,
  input logic               cfg_update_i,
  input logic [HINC_W-1:0]  hinc_eff,
  input logic [HINC_W-1:0]  hinc_shadow,
  input logic [VSTEP_W-1:0] vstep_eff,
  input logic [PHASE_W-1:0] h_acc,
  input logic [VSTEP_W-1:0] v_cnt,
  input logic               v_sel,
  input logic               pix_valid_q_o,
  input logic               sample_en_o
);
  localparam logic [HINC_W-1:0] FULL_INC = HINC_W'(1) << PHASE_W;

  AST_EN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> pix_valid_q_o); // R2
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_i |=> pix_valid_q_o); // R2
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_i && hinc_eff >= FULL_INC && v_sel) |=> sample_en_o); // R3
  AST_ZERO_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_i && hinc_eff == '0) |=> !sample_en_o); // R5
  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_i && !pix_valid_i) |=> (h_acc == '0)); // R6
  AST_STEP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    vstep_eff >= VSTEP_W'(VSTEP_MIN)); // R8
  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (v_cnt == '0)); // R9
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start_i && !cfg_update_i) |=> $stable(hinc_shadow)); // R10
endmodule

bind pix_subsample_gate pix_subsample_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i),
  .line_start_i(line_start_i), .frame_start_i(frame_start_i),
  .cfg_update_i(cfg_update_i), .hinc_eff(hinc_eff), .hinc_shadow(hinc_shadow),
  .vstep_eff(vstep_eff), .h_acc(h_acc), .v_cnt(v_cnt), .v_sel(v_sel),
  .pix_valid_q_o(pix_valid_q_o), .sample_en_o(sample_en_o)
);

// File: tb/pix_subsample_gate_tb.sv
module pix_subsample_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_valid_i, line_start_i, frame_start_i, cfg_update_i;
  logic [16:0] cfg_hinc_i;
  logic [6:0]  cfg_vstep_i;
  logic        pix_valid_q_o, sample_en_o;

  int checks = 0;
  int errors = 0;
  longint m_h;   // increment currently in force
  int     m_n;   // step currently in force (clamped)
  int     m_v;   // line position within the step cycle

  always #5 clk = ~clk;

  pix_subsample_gate u_dut (
    .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i),
    .line_start_i(line_start_i), .frame_start_i(frame_start_i),
    .cfg_update_i(cfg_update_i), .cfg_hinc_i(cfg_hinc_i),
    .cfg_vstep_i(cfg_vstep_i), .pix_valid_q_o(pix_valid_q_o),
    .sample_en_o(sample_en_o)
  );

  function automatic int clamp_step(input int n);
    return (n < 3) ? 3 : n;
  endfunction

  function automatic bit pix_hit(input longint h, input int j);
    return ((longint'(j + 1) * h) / 65536) > ((longint'(j) * h) / 65536);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at falling edge, check registered result after rising edge
  task automatic cyc(input logic v, input logic ls, input logic fs,
                     input logic upd, input logic exp, input string req);
    @(negedge clk);
    pix_valid_i = v; line_start_i = ls; frame_start_i = fs; cfg_update_i = upd;
    @(posedge clk);
    #1;
    check({req, " en"}, sample_en_o, exp);
    check("R2 valid delay", pix_valid_q_o, v);
  endtask

  task automatic run_line(input int pixels, input int gap, input bit first, input string req);
    bit sel;
    if (first) m_v = 0;
    else m_v = (m_v >= m_n - 1) ? 0 : m_v + 1;
    sel = (m_v == 0);
    for (int j = 0; j < pixels; j++) begin
      cyc(1'b1, j == 0, first && j == 0, 1'b0, sel && pix_hit(m_h, j), req);
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 idle");
    end
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 line gap");
  endtask

  task automatic run_frame(input int h, input int n, input int lines,
                           input int pixels, input int gap, input string req);
    @(negedge clk);
    cfg_hinc_i = 17'(h); cfg_vstep_i = 7'(n);
    m_h = h; m_n = clamp_step(n);
    for (int k = 0; k < lines; k++) run_line(pixels, gap, k == 0, req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    pix_valid_i = 1'b0; line_start_i = 1'b0; frame_start_i = 1'b0; cfg_update_i = 1'b0;
    cfg_hinc_i = '0; cfg_vstep_i = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 en in reset", sample_en_o, 1'b0);
    check("R1 valid in reset", pix_valid_q_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 en after reset", sample_en_o, 1'b0);
    check("R1 valid after reset", pix_valid_q_o, 1'b0);
  endtask

  task automatic t_full_and_half;
    run_frame(65536, 3, 7, 5, 0, "R3 full rate step3 R7");
    run_frame(32768, 4, 5, 6, 0, "R3 half rate R7");
  endtask

  task automatic t_fractional;
    run_frame(21845, 3, 4, 10, 1, "R4 third rate with gaps");
    run_frame(40000, 5, 6, 9, 2, "R4 0.61 rate R6");
    run_frame(50000, 3, 4, 3, 0, "R6 short lines");
  endtask

  task automatic t_extremes;
    run_frame(0, 3, 3, 6, 0, "R5 zero increment");
    run_frame(100000, 3, 4, 5, 0, "R5 above full");
    run_frame(131071, 6, 7, 3, 0, "R5 max increment");
  endtask

  task automatic t_clamp;
    run_frame(65536, 1, 7, 2, 0, "R8 step1 clamp");
    run_frame(65536, 0, 4, 2, 0, "R8 step0 clamp");
    run_frame(65536, 2, 4, 2, 0, "R8 step2 clamp");
  endtask

  task automatic t_frame_restart;
    run_frame(65536, 4, 2, 3, 0, "R9 partial frame");
    run_frame(65536, 4, 5, 3, 0, "R9 restart selects line 0");
  endtask

  task automatic t_cfg_hold;
    run_frame(65536, 3, 1, 4, 0, "R10 base frame");
    // change inputs without a strobe: old settings must stay
    @(negedge clk);
    cfg_hinc_i = 17'd32768; cfg_vstep_i = 7'd5;
    for (int k = 0; k < 3; k++) run_line(4, 0, 1'b0, "R10 no strobe keeps old");
    // lone update strobe on an idle cycle
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R10 update strobe");
    m_h = 32768; m_n = 5;
    for (int k = 0; k < 7; k++) run_line(4, 0, 1'b0, "R10 after update R7");
  endtask

  initial begin
    t_reset();
    t_full_and_half();
    t_fractional();
    t_extremes();
    t_clamp();
    t_frame_restart();
    t_cfg_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule